// File: doc/BRIEF.md
# Host-Fed Pixel Expander

This block sits on the host-source path of a 2D blit engine. When a command that names the host data port as its pixel source is accepted, the block works out how many 32-bit words the CPU must push. It then takes those words one at a time and turns each into destination pixels on a valid/ready stream. Address generation and memory writes happen downstream and are not part of this block.

Two source modes exist. In mono mode every source bit picks one of two colours: the foreground colour for a 1 and the background colour for a 0. In colour mode the word's bytes are cut into pixels of 1, 2 or 4 bytes. The expected word count always covers whole words. The word count treats a mono pixel as one byte, so a mono transfer takes more words than its bits fill, and the surplus words are accepted and dropped. When the last expected word has been taken and its pixels have left, a one-cycle done pulse marks the end of the transfer. The data port then refuses further writes until the next command.

Top module: `hxp_host_expand`

## Requirements
- R1: While reset is applied, and directly after it, `wr_ready`, `out_valid` and `done` are low.
- R2: A command is taken only when bit 6 of `cmd_word` is set (host source). A command with bit 6 clear starts nothing, and `wr_ready` stays low.
- R3: Mono mode is chosen only when bits 1, 8 and 17 of `cmd_word` are all set. If any of them is clear, the transfer is a colour transfer.
- R4: The number of words accepted equals ceil(P×B/4), where P = (`ext_w_m1`+1)×(`ext_h_m1`+1) and B is 1 in mono mode. In colour mode B comes from `fmt_sel`: 0 gives 1 byte, 1 gives 2 bytes, 2 or 3 gives 4 bytes.
- R5: In mono mode, bits are used byte 0 first (bits 7:0), and most significant bit first within each byte. A 1 emits the foreground colour and a 0 emits the background colour.
- R6: In colour mode, pixels are taken from the lowest byte lane upward and zero-extended to 32 bits. A word yields 4 pixels at 1 byte, 2 pixels at 2 bytes and 1 pixel at 4 bytes.
- R7: Exactly P pixels leave the block per transfer. Source bits or words beyond the last pixel are discarded.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_pixel` hold their values.
- R9: `done` is high for exactly one cycle, once the last expected word has been taken and its pixels have been delivered. After that, `wr_ready` stays low and writes on the data port have no effect.
- R10: A command is accepted when the block is idle or in the cycle that `done` is high. A command that arrives during any other busy cycle is ignored.
- R11: The foreground and background colours, the size and the format are captured when the command is accepted. Later changes on those inputs do not affect the running transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_word | input | 32 | Command word (bit 6 host source; bits 1, 8, 17 mono) |
| fmt_sel | input | 2 | Destination pixel size for colour mode |
| ext_w_m1 | input | DIM_W | Width minus one |
| ext_h_m1 | input | DIM_W | Height minus one |
| fg_colour | input | 32 | Foreground colour |
| bg_colour | input | 32 | Background colour |
| wr_valid | input | 1 | Host data word valid |
| wr_data | input | 32 | Host data word |
| wr_ready | output | 1 | Data port can take a word |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Downstream takes the pixel |
| out_pixel | output | 32 | Destination pixel |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The end of one transfer and the start of the next can share a cycle. The bench holds a new host-source command on the port in the exact cycle that `done` shows, so the new command is sampled together with the finishing state. A reference model tracks word budget, pixel queue and busy state per clock. It expects the second transfer's `wr_ready` to rise straight after, with its own word count, and it checks that no word or pixel of the first transfer spills into it. A command held during the middle of a busy transfer checks the opposite case, which must leave the running transfer untouched.

// File: rtl/hxp_pkg.sv
package hxp_pkg;
  localparam int unsigned CMD_HOST_BIT  = 6;
  localparam int unsigned CMD_MONO_BIT0 = 1;
  localparam int unsigned CMD_MONO_BIT1 = 8;
  localparam int unsigned CMD_MONO_BIT2 = 17;

  // log2 of bytes per pixel
  localparam logic [1:0] LG_B1 = 2'd0;
  localparam logic [1:0] LG_B2 = 2'd1;
  localparam logic [1:0] LG_B4 = 2'd2;

  typedef struct packed {
    logic       mono;
    logic [1:0] lg;
  } xfer_mode_t;
endpackage

// File: rtl/hxp_cmd_decode.sv
module hxp_cmd_decode
  import hxp_pkg::*;
(
  input  logic [31:0] cmd_word,
  input  logic [1:0]  fmt_sel,
  output logic        host_src,
  output xfer_mode_t  mode
);
  logic cmd_rest_unused;
  assign cmd_rest_unused = ^cmd_word;

  always_comb begin
    host_src  = cmd_word[CMD_HOST_BIT];
    mode.mono = cmd_word[CMD_MONO_BIT0] & cmd_word[CMD_MONO_BIT1] &
                cmd_word[CMD_MONO_BIT2];
    if (mode.mono) begin
      mode.lg = LG_B1;
    end else begin
      case (fmt_sel)
        2'd0:    mode.lg = LG_B1;
        2'd1:    mode.lg = LG_B2;
        default: mode.lg = LG_B4;
      endcase
    end
  end
endmodule

// File: rtl/hxp_word_ctr.sv
module hxp_word_ctr #(
  parameter int CW = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          is_zero
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | dec;
    cnt_d  = load ? load_val : cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign is_zero = (cnt_q == '0);

  AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> !is_zero); // R4
endmodule

// File: rtl/hxp_unpack.sv
module hxp_unpack
  import hxp_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IDX_W  = $clog2(WORD_W),
  parameter int CNT_W  = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              step,
  input  xfer_mode_t        mode,
  input  logic [WORD_W-1:0] fg,
  input  logic [WORD_W-1:0] bg,
  output logic              pix_valid,
  output logic [WORD_W-1:0] pixel
);
  logic [WORD_W-1:0] buf_q, buf_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              buf_en;
  logic [IDX_W-1:0]  bit_sel;
  logic [IDX_W-1:0]  shamt;
  logic [WORD_W-1:0] shifted;
  logic [WORD_W-1:0] col_pix;

  always_comb begin
    buf_en = load | step;
    if (load) begin
      buf_d = load_word;
      idx_d = '0;
      cnt_d = load_cnt;
    end else begin
      buf_d = buf_q;
      idx_d = idx_q + IDX_W'(1);
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      idx_q <= '0;
      cnt_q <= '0;
    end else if (buf_en) begin
      buf_q <= buf_d;
      idx_q <= idx_d;
      cnt_q <= cnt_d;
    end
  end

  // mono: byte order ascending, bit order descending within the byte
  always_comb begin
    bit_sel = {idx_q[IDX_W-1:3], ~idx_q[2:0]};
    shamt   = {idx_q[IDX_W-4:0], 3'b000} << mode.lg;
    shifted = buf_q >> shamt;
    case (mode.lg)
      LG_B1:   col_pix = {{(WORD_W-8){1'b0}},  shifted[7:0]};
      LG_B2:   col_pix = {{(WORD_W-16){1'b0}}, shifted[15:0]};
      default: col_pix = shifted;
    endcase
    pix_valid = (cnt_q != '0);
    pixel     = mode.mono ? (buf_q[bit_sel] ? fg : bg) : col_pix;
  end

  AST_LOAD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !pix_valid); // R7
  AST_LOAD_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_cnt <= CNT_W'(WORD_W))); // R7
endmodule

// File: rtl/hxp_host_expand.sv
module hxp_host_expand
  import hxp_pkg::*;
#(
  parameter int DIM_W  = 12,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [31:0]       cmd_word,
  input  logic [1:0]        fmt_sel,
  input  logic [DIM_W-1:0]  ext_w_m1,
  input  logic [DIM_W-1:0]  ext_h_m1,
  input  logic [WORD_W-1:0] fg_colour,
  input  logic [WORD_W-1:0] bg_colour,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_pixel,
  output logic              done
);
  localparam int PIX_W  = 2 * DIM_W + 1;
  localparam int BYTE_W = PIX_W + 2;
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int CNT_W  = IDX_W + 1;
  localparam int LANES  = WORD_W / 8;

  // asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta_q} <= 2'b00;
    else        {rst_sync_n, rst_meta_q} <= {rst_meta_q, 1'b1};
  end

  logic       host_src;
  xfer_mode_t mode_dec;

  hxp_cmd_decode u_dec (
    .cmd_word (cmd_word),
    .fmt_sel  (fmt_sel),
    .host_src (host_src),
    .mode     (mode_dec)
  );

  logic              busy_q, busy_d;
  xfer_mode_t        mode_q;
  logic [WORD_W-1:0] fg_q, bg_q;
  logic [PIX_W-1:0]  unq_q, unq_d;
  logic              start, load, step, words_zero, buf_valid, unq_en;
  logic [PIX_W-1:0]  w_cnt, h_cnt, pix_total;
  logic [BYTE_W-1:0] byte_total, rnd_sum;
  logic [PIX_W-1:0]  word_total;
  logic [CNT_W-1:0]  per_word, take;
  logic              rnd_unused;

  // transfer sizing at command time
  always_comb begin
    w_cnt      = PIX_W'(ext_w_m1) + PIX_W'(1);
    h_cnt      = PIX_W'(ext_h_m1) + PIX_W'(1);
    pix_total  = w_cnt * h_cnt;
    byte_total = BYTE_W'(pix_total) << mode_dec.lg;
    rnd_sum    = byte_total + BYTE_W'(3);
    word_total = rnd_sum[BYTE_W-1:2];
  end
  assign rnd_unused = ^rnd_sum[1:0];

  always_comb begin
    wr_ready = busy_q && !words_zero && !buf_valid;
    done     = busy_q && words_zero && !buf_valid;
    start    = cmd_valid && host_src && (!busy_q || done);
    load     = wr_ready && wr_valid;
    step     = buf_valid && out_ready;
    per_word = mode_q.mono ? CNT_W'(WORD_W) : CNT_W'(LANES >> mode_q.lg);
    take     = (unq_q < PIX_W'(per_word)) ? CNT_W'(unq_q) : per_word;
    busy_d   = start ? 1'b1 : (done ? 1'b0 : busy_q);
    unq_en   = start | load;
    unq_d    = start ? pix_total : unq_q - PIX_W'(take);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) busy_q <= 1'b0;
    else             busy_q <= busy_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q <= '0;
      fg_q   <= '0;
      bg_q   <= '0;
    end else if (start) begin
      mode_q <= mode_dec;
      fg_q   <= fg_colour;
      bg_q   <= bg_colour;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  unq_q <= '0;
    else if (unq_en)  unq_q <= unq_d;
  end

  hxp_word_ctr #(.CW(PIX_W)) u_words (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (start),
    .load_val (word_total),
    .dec      (load),
    .is_zero  (words_zero)
  );

  hxp_unpack #(.WORD_W(WORD_W)) u_unpack (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (load),
    .load_word (wr_data),
    .load_cnt  (take),
    .step      (step),
    .mode      (mode_q),
    .fg        (fg_q),
    .bg        (bg_q),
    .pix_valid (buf_valid),
    .pixel     (out_pixel)
  );

  assign out_valid = buf_valid;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !busy_q |-> (!wr_ready && !out_valid)); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel))); // R8
  AST_DONE_ALL_PIX: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> (unq_q == '0)); // R7
  AST_START_ARMS_PORT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start |=> (wr_ready && !done)); // R10
endmodule

// File: tb/test_hxp_host_expand.sv
module test_hxp_host_expand;
  localparam int CLK_PERIOD = 10;
  localparam int DIM_W      = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [31:0] cmd_word;
  logic [1:0]  fmt_sel;
  logic [DIM_W-1:0] ext_w_m1, ext_h_m1;
  logic [31:0] fg_colour, bg_colour;
  logic        wr_valid;
  logic [31:0] wr_data;
  logic        wr_ready, out_valid, out_ready, done;
  logic [31:0] out_pixel;

  always #(CLK_PERIOD/2) clk = ~clk;

  hxp_host_expand #(.DIM_W(DIM_W), .WORD_W(32)) i_hxp_host_expand (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .fmt_sel(fmt_sel), .ext_w_m1(ext_w_m1), .ext_h_m1(ext_h_m1),
    .fg_colour(fg_colour), .bg_colour(bg_colour), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ready(wr_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_pixel(out_pixel), .done(done)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int acc_cnt = 0, done_cnt = 0, pix_rx = 0;
  bit stall_en = 0, cmp_en = 0, finished = 0;

  // behavioural reference model
  bit          m_busy = 0, m_mono = 0;
  int          m_words = 0, m_unq = 0, m_b = 1;
  logic [31:0] m_fg, m_bg;
  logic [31:0] q[$];

  // chained command armed for the done cycle
  bit          chain_arm = 0;
  logic [31:0] ch_cmd;
  logic [1:0]  ch_fmt;
  int          ch_w, ch_h;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic int bpp_of(input logic [31:0] c, input logic [1:0] f);
    if (c[1] && c[8] && c[17]) return 1;
    case (f)
      2'd0: return 1;
      2'd1: return 2;
      default: return 4;
    endcase
  endfunction

  function automatic int exp_words(input logic [31:0] c, input logic [1:0] f,
                                   input int w, input int h);
    return ((w + 1) * (h + 1) * bpp_of(c, f) + 3) / 4;
  endfunction

  function automatic logic [31:0] word_of(input int i);
    return (32'h9E37_79B9 * (i + 1)) ^ 32'h5A0F_C3A5;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_words = 0; m_unq = 0; q.delete();
    end else begin
      bit rdy, ov, dn;
      rdy = m_busy && m_words > 0 && q.size() == 0;
      ov  = q.size() > 0;
      dn  = m_busy && m_words == 0 && q.size() == 0;
      if (ov && out_ready) begin
        void'(q.pop_front());
        pix_rx++;
      end
      if (rdy && wr_valid) begin
        int per, take;
        m_words--;
        acc_cnt++;
        per  = m_mono ? 32 : 4 / m_b;
        take = (m_unq < per) ? m_unq : per;
        for (int k = 0; k < take; k++) begin
          if (m_mono) begin
            q.push_back(wr_data[(k / 8) * 8 + 7 - (k % 8)] ? m_fg : m_bg);
          end else begin
            longint v;
            v = (longint'(wr_data) >> (k * 8 * m_b)) &
                ((longint'(1) << (8 * m_b)) - 1);
            q.push_back(v[31:0]);
          end
        end
        m_unq -= take;
      end
      if (dn) begin
        m_busy = 0;
        done_cnt++;
      end
      if (cmd_valid && cmd_word[6] && !m_busy) begin
        m_busy  = 1;
        m_mono  = cmd_word[1] && cmd_word[8] && cmd_word[17];
        m_b     = bpp_of(cmd_word, fmt_sel);
        m_unq   = (int'(ext_w_m1) + 1) * (int'(ext_h_m1) + 1);
        m_words = (m_unq * m_b + 3) / 4;
        m_fg    = fg_colour;
        m_bg    = bg_colour;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "WDOG", "watchdog expired", cyc, 150000);
      finish_run();
    end
    out_ready = stall_en ? 1'($urandom_range(0, 1)) : 1'b1;
    if (cmp_en) begin
      bit e_rdy, e_ov, e_dn;
      e_rdy = m_busy && m_words > 0 && q.size() == 0;
      e_ov  = q.size() > 0;
      e_dn  = m_busy && m_words == 0 && q.size() == 0;
      chk(wr_ready == e_rdy, "R2", "wr_ready", wr_ready, e_rdy);
      chk(out_valid == e_ov, "R7", "out_valid", out_valid, e_ov);
      chk(done == e_dn, "R9", "done", done, e_dn);
      if (e_ov)
        chk(out_pixel == q[0], m_mono ? "R5/R8" : "R6/R8", "out_pixel",
            out_pixel, q[0]);
    end
  end

  task automatic start(input logic [31:0] c, input logic [1:0] f,
                       input int w, input int h,
                       input logic [31:0] fg, input logic [31:0] bg);
    cmd_word = c; fmt_sel = f;
    ext_w_m1 = DIM_W'(w); ext_h_m1 = DIM_W'(h);
    fg_colour = fg; bg_colour = bg;
    cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    // R11: inputs moved after acceptance must not matter
    fg_colour = ~fg; bg_colour = ~bg;
    ext_w_m1 = ~ext_w_m1; fmt_sel = ~f;
  endtask

  task automatic feed(input int ew, input int ep, input bit tail,
                      input string tag);
    int base_acc, base_done, base_pix, hold;
    base_acc = acc_cnt; base_done = done_cnt; base_pix = pix_rx;
    wr_valid = 1;
    while (done_cnt == base_done) begin
      wr_data = word_of(acc_cnt - base_acc);
      if (chain_arm && done) begin
        cmd_word = ch_cmd; fmt_sel = ch_fmt;
        ext_w_m1 = DIM_W'(ch_w); ext_h_m1 = DIM_W'(ch_h);
        cmd_valid = 1;
        chain_arm = 0;
      end
      @(negedge clk);
    end
    cmd_valid = 0;
    chk(acc_cnt - base_acc == ew, "R4", {tag, " words accepted"},
        acc_cnt - base_acc, ew);
    chk(pix_rx - base_pix == ep, "R7", {tag, " pixels delivered"},
        pix_rx - base_pix, ep);
    if (tail) begin
      hold = acc_cnt;
      repeat (4) @(negedge clk);
      chk(acc_cnt == hold && !wr_ready && !out_valid, "R9",
          {tag, " writes after done"}, acc_cnt - hold, 0);
    end
    wr_valid = 0;
  endtask

  task automatic run(input logic [31:0] c, input logic [1:0] f,
                     input int w, input int h, input bit stall,
                     input string tag);
    stall_en = stall;
    start(c, f, w, h, 32'hF0F0_1234, 32'h0B0B_5678);
    feed(exp_words(c, f, w, h), (w + 1) * (h + 1), 1, tag);
  endtask

  localparam logic [31:0] C_MONO = 32'h0002_0142;
  localparam logic [31:0] C_COL  = 32'h0000_0041;
  localparam logic [31:0] C_PART = 32'h0000_0142;
  localparam logic [31:0] C_MEM  = 32'h0002_0103;

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_word = '0; fmt_sel = '0;
    ext_w_m1 = '0; ext_h_m1 = '0; fg_colour = '0; bg_colour = '0;
    wr_valid = 0; wr_data = '0; out_ready = 1;
    repeat (3) @(negedge clk);
    chk(!wr_ready && !out_valid && !done, "R1", "outputs in reset",
        {wr_ready, out_valid, done}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!wr_ready && !out_valid && !done, "R1", "outputs after reset",
        {wr_ready, out_valid, done}, 0);
    cmp_en = 1;

    run(C_MONO, 2'd2, 9, 2, 0, "mono P30");          // R5 R7: surplus words
    run(C_MONO, 2'd0, 34, 1, 1, "mono P70 stall");   // R5 R8
    run(C_COL, 2'd0, 4, 1, 1, "8bpp");               // R6
    run(C_COL, 2'd1, 2, 0, 0, "16bpp");              // R6
    run(C_COL, 2'd2, 1, 1, 1, "32bpp");              // R6 R8
    run(C_COL, 2'd3, 2, 0, 0, "fmt3 32bpp");         // R4
    run(C_PART, 2'd1, 4, 0, 0, "R3 partial mono");   // R3: colour, 3 words

    // R2: no host-source bit, nothing starts
    start(C_MEM, 2'd0, 3, 3, 32'h1, 32'h2);
    repeat (5) @(negedge clk);
    chk(!wr_ready && done_cnt == 7, "R2", "memory-source command ignored",
        wr_ready, 0);

    // R10: command during a busy transfer is ignored
    stall_en = 0;
    start(C_COL, 2'd0, 7, 0, 32'h0, 32'h0);
    start(C_MONO, 2'd0, 40, 3, 32'hAAAA_AAAA, 32'h5555_5555);
    feed(2, 8, 1, "R10 busy ignore");

    // R10: command in the done cycle starts the next transfer
    stall_en = 1;
    ch_cmd = C_COL; ch_fmt = 2'd1; ch_w = 1; ch_h = 0;
    chain_arm = 1;
    start(C_MONO, 2'd0, 3, 0, 32'hCAFE_0001, 32'hBEEF_0002);
    feed(1, 4, 0, "R10 first of chain");
    chk(m_busy && wr_ready, "R10", "next transfer armed", wr_ready, 1);
    feed(1, 2, 1, "R10 second of chain");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule